// File: doc/BRIEF.md
# Multicycle Issue Hazard Controller

This block sits at the decode stage of an in-order, single-issue pipeline that owns several execution units with unequal result latencies. Every cycle it looks at the instruction waiting in decode and decides whether it may issue or must be held. It keeps a count of remaining result cycles for every architectural register, a countdown for the non-pipelined divider, and a shifting reservation vector for the single writeback slot. Decode presents the request, reads `stall` in the same cycle, and advances only on `issue_fire`.

Latency counts the cycles between producer and consumer, so a consumer may issue L+1 cycles after its producer. Results can retire out of order. A younger write must never land before an older write to the same register, and two instructions must never share a writeback cycle. Source reads happen in order in decode, so write-after-read needs no check.

Top module: `hz_issue_ctrl`

## Requirements
- R1: After reset no register is pending, the divider is idle, and `stall` and `issue_fire` are both low while `req_valid` is low.
- R2: Unit codes on `req_unit` map to these latencies: 0 integer = 0, 1 load = 1, 2 add = 3, 3 multiply = 6, 4 divide = 24; codes 5 to 7 behave as integer. A request reading a register that an earlier instruction of latency L writes first issues exactly L+1 cycles after that producer issued, unless another rule holds it longer.
- R3: `reg_pending[r]` is high for exactly the L cycles that follow the issue of a writer of register r with latency L, and low otherwise.
- R4: The divider accepts a new divide no earlier than 25 cycles after the previous one issued. `div_busy` is high for the 24 cycles after a divide issues. Non-divide requests are not held by a busy divider.
- R5: Every issued instruction, writing or not, claims the writeback cycle that lies its latency after its issue cycle. A request whose writeback cycle is already claimed stalls.
- R6: A writing request stalls while its destination still has more remaining cycles than the request's own latency. With equal or fewer remaining cycles it is not held by this rule.
- R7: A source is checked only when its bit in `req_src_en` is set (bit 0 for `req_src1`, bit 1 for `req_src2`). A request with `req_wr` low does not mark its destination pending.
- R8: With `req_valid` low, `stall` and `issue_fire` stay low and no register or writeback slot is claimed.
- R9: `stall` and `issue_fire` respond in the same cycle as the request. `issue_fire` is high exactly when a valid request has no hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An instruction waits in decode |
| req_unit | input | 3 | Execution unit code |
| req_wr | input | 1 | Instruction writes a destination register |
| req_dst | input | 5 | Destination register number |
| req_src_en | input | 2 | Source-read enables |
| req_src1 | input | 5 | First source register number |
| req_src2 | input | 5 | Second source register number |
| stall | output | 1 | Request is held this cycle |
| issue_fire | output | 1 | Request issues at the coming edge |
| reg_pending | output | 32 | Per-register result-not-yet-usable flags |
| div_busy | output | 1 | Divider still occupied |

## Verification
Every producer unit is paired with every consumer code (including an unused one) in three patterns. The first is a true dependence through either source port. The second is a rewrite of the same destination with the sources switched off. The third is an unrelated non-writing producer. Each pattern starts the consumer one to three cycles late. The dependence pattern measures the L+1 gap and the pending window. The rewrite pattern separates the write-order rule from the disabled sources. The unrelated pattern leaves only writeback collisions and divider occupancy to cause stalls. Which collision happens depends on the consumer's arrival offset, so the offsets tell apart a slot clash from a plain latency wait.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    UNIT_INT  = 3'd0,
    UNIT_LOAD = 3'd1,
    UNIT_ADD  = 3'd2,
    UNIT_MUL  = 3'd3,
    UNIT_DIV  = 3'd4
  } unit_e;

  // Latency in intervening cycles for a unit code; unknown codes act as integer.
  function automatic int unsigned unit_lat(input logic [2:0] code,
                                           input int unsigned l_load,
                                           input int unsigned l_add,
                                           input int unsigned l_mul,
                                           input int unsigned l_div);
    case (code)
      UNIT_LOAD: return l_load;
      UNIT_ADD:  return l_add;
      UNIT_MUL:  return l_mul;
      UNIT_DIV:  return l_div;
      default:   return 0;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int NREGS = 32,
  parameter int RW    = 5,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_dst,
  input  logic [CW-1:0]    wr_lat,
  input  logic [RW-1:0]    rd_a,
  input  logic [RW-1:0]    rd_b,
  output logic [CW-1:0]    dst_cnt,
  output logic             pend_a,
  output logic             pend_b,
  output logic [NREGS-1:0] pending
);
  logic [CW-1:0] cnt [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_dst == RW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)              cnt[i] <= '0;
      else if (hit)            cnt[i] <= wr_lat;
      else if (cnt[i] != '0)   cnt[i] <= cnt[i] - 1'b1;
    end
    assign pending[i] = (cnt[i] != '0);

    // R3: an untouched pending count falls by exactly one per cycle
    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[i] && !hit) |=> (cnt[i] == $past(cnt[i]) - 1'b1));
  end

  assign dst_cnt = cnt[wr_dst];
  assign pend_a  = pending[rd_a];
  assign pend_b  = pending[rd_b];

  // R3: a writer with nonzero latency makes its register pending next cycle
  assert_pend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lat != '0) |=> pending[$past(wr_dst)]);
endmodule

// File: rtl/hz_wb_reserve.sv
module hz_wb_reserve #(
  parameter int MAXL = 24,
  parameter int CW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim_en,
  input  logic [CW-1:0] claim_lat,
  output logic          slot_taken
);
  logic [MAXL:0] res;
  logic [CW-1:0] claim_m1;

  for (genvar i = 0; i <= MAXL; i++) begin : g_slot
    if (i < MAXL) begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n) res[i] <= 1'b0;
        else        res[i] <= res[i+1] | (claim_en && claim_lat == CW'(i + 1));
      end
    end else begin : g_top
      always_ff @(posedge clk) res[i] <= 1'b0;
    end
  end

  assign slot_taken = res[claim_lat];
  assign claim_m1   = claim_lat - 1'b1;

  // R5: a claim at distance L shows up at distance L-1 one cycle later
  assert_claim_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && claim_lat != '0) |=> res[$past(claim_m1)]);
endmodule

// File: rtl/hz_div_track.sv
module hz_div_track #(
  parameter int DIV_II = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int DW = $clog2(DIV_II + 1);
  logic [DW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)            left <= '0;
    else if (start)        left <= DW'(DIV_II - 1);
    else if (left != '0)   left <= left - 1'b1;
  end
  assign busy = (left != '0);

  // R4: accepting a divide occupies the divider from the next cycle on
  assert_div_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R4: no new divide may start while the divider is occupied
  assert_div_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/hz_issue_ctrl.sv
module hz_issue_ctrl #(
  parameter int NREGS  = 32,
  parameter int LAT_LD = 1,
  parameter int LAT_AD = 3,
  parameter int LAT_MU = 6,
  parameter int LAT_DV = 24,
  parameter int DIV_II = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_unit,
  input  logic                     req_wr,
  input  logic [$clog2(NREGS)-1:0] req_dst,
  input  logic [1:0]               req_src_en,
  input  logic [$clog2(NREGS)-1:0] req_src1,
  input  logic [$clog2(NREGS)-1:0] req_src2,
  output logic                     stall,
  output logic                     issue_fire,
  output logic [NREGS-1:0]         reg_pending,
  output logic                     div_busy
);
  import hz_pkg::*;

  localparam int RW   = $clog2(NREGS);
  localparam int MAXL = int'(max2(max2(LAT_LD, LAT_AD), max2(LAT_MU, LAT_DV)));
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] lat, dst_cnt;
  logic          is_div, pend_a, pend_b, slot_taken;
  logic          raw_hit, waw_hit, wb_hit, div_hit, hazard;

  assign lat    = CW'(unit_lat(req_unit, LAT_LD, LAT_AD, LAT_MU, LAT_DV));
  assign is_div = (req_unit == UNIT_DIV);

  hz_scoreboard #(.NREGS(NREGS), .RW(RW), .CW(CW)) sb_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(issue_fire && req_wr), .wr_dst(req_dst), .wr_lat(lat),
    .rd_a(req_src1), .rd_b(req_src2),
    .dst_cnt(dst_cnt), .pend_a(pend_a), .pend_b(pend_b), .pending(reg_pending)
  );

  hz_wb_reserve #(.MAXL(MAXL), .CW(CW)) wb_i (
    .clk(clk), .rst_n(rst_n),
    .claim_en(issue_fire), .claim_lat(lat), .slot_taken(slot_taken)
  );

  hz_div_track #(.DIV_II(DIV_II)) dv_i (
    .clk(clk), .rst_n(rst_n), .start(issue_fire && is_div), .busy(div_busy)
  );

  assign raw_hit    = (req_src_en[0] && pend_a) || (req_src_en[1] && pend_b);
  assign waw_hit    = req_wr && (dst_cnt > lat);
  assign wb_hit     = slot_taken;
  assign div_hit    = is_div && div_busy;
  assign hazard     = raw_hit || waw_hit || wb_hit || div_hit;
  assign stall      = req_valid && hazard;
  assign issue_fire = req_valid && !hazard;

  // R2: an issued request never reads an enabled source that is still pending
  assert_no_raw_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> !((req_src_en[0] && reg_pending[req_src1]) ||
                     (req_src_en[1] && reg_pending[req_src2])));
  // R6: an issued writer never finishes before the older writer of its register
  assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && req_wr) |-> (dst_cnt <= lat));
  // R8: nothing issues or stalls without a valid request
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(stall || issue_fire));
endmodule

// File: tb/hz_issue_ctrl_tb_top.sv
module hz_issue_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MODE_RAW = 0, MODE_WAW = 1, MODE_IND = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_unit = '0;
  logic        req_wr = 1'b0;
  logic [4:0]  req_dst = '0;
  logic [1:0]  req_src_en = '0;
  logic [4:0]  req_src1 = '0;
  logic [4:0]  req_src2 = '0;
  logic        stall, issue_fire, div_busy;
  logic [31:0] reg_pending;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  hz_issue_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_unit(req_unit),
    .req_wr(req_wr), .req_dst(req_dst), .req_src_en(req_src_en),
    .req_src1(req_src1), .req_src2(req_src2), .stall(stall),
    .issue_fire(issue_fire), .reg_pending(reg_pending), .div_busy(div_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lat_of(input int u);
    case (u)
      1: return 1;
      2: return 3;
      3: return 6;
      4: return 24;
      default: return 0;
    endcase
  endfunction

  // Remaining cycles of the producer's destination k cycles after it issued.
  function automatic int left_of(input int p, input int k);
    int r;
    r = lat_of(p) - (k - 1);
    return (r > 0) ? r : 0;
  endfunction

  // Whether the consumer may issue in cycle k after the producer, from R2 R4 R5 R6.
  function automatic bit may_issue(input int mode, input int p, input int c, input int k);
    int lp, lc, left;
    bit ok;
    lp   = lat_of(p);
    lc   = lat_of(c);
    left = (mode == MODE_IND) ? 0 : left_of(p, k);
    ok   = 1'b1;
    if (mode == MODE_RAW && left != 0) ok = 1'b0;
    if (mode == MODE_WAW && left > lc) ok = 1'b0;
    if (k + lc == lp) ok = 1'b0;
    if (p == 4 && c == 4 && k < 25) ok = 1'b0;
    return ok;
  endfunction

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_checks++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_req();
    req_valid = 1'b0; req_wr = 1'b0; req_src_en = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic run_case(input int mode, input int p, input int c, input int d);
    int k;
    bit fired;
    step();
    idle_req();
    settle();
    chk(reg_pending == '0 && !div_busy, "R1", int'(reg_pending != '0), 0);
    // producer
    req_valid = 1'b1; req_unit = 3'(p);
    req_wr = (mode != MODE_IND); req_dst = (mode == MODE_IND) ? 5'd9 : 5'd1;
    req_src_en = '0; req_src1 = 5'd20; req_src2 = 5'd21;
    settle();
    chk(issue_fire && !stall, "R9", int'(issue_fire), 1);
    k = 0;
    fired = 1'b0;
    while (!fired && k < 45) begin
      step();
      k++;
      if (k < d) begin
        idle_req();
        settle();
        chk(!stall && !issue_fire, "R8", int'(stall || issue_fire), 0);
      end else begin
        req_valid = 1'b1; req_unit = 3'(c);
        if (mode == MODE_RAW) begin
          req_wr = 1'b1; req_dst = 5'd2;
          req_src_en = (d % 2 == 1) ? 2'b01 : 2'b10;
          req_src1 = (d % 2 == 1) ? 5'd1 : 5'd7;
          req_src2 = (d % 2 == 1) ? 5'd7 : 5'd1;
        end else if (mode == MODE_WAW) begin
          req_wr = 1'b1; req_dst = 5'd1;
          req_src_en = 2'b00; req_src1 = 5'd1; req_src2 = 5'd1;
        end else begin
          req_wr = 1'b1; req_dst = 5'd3;
          req_src_en = 2'b11; req_src1 = 5'd9; req_src2 = 5'd9;
        end
        settle();
        if (mode == MODE_RAW)
          chk(issue_fire == may_issue(mode, p, c, k), "R2", int'(issue_fire),
              int'(may_issue(mode, p, c, k)));
        else if (mode == MODE_WAW)
          chk(issue_fire == may_issue(mode, p, c, k), "R6", int'(issue_fire),
              int'(may_issue(mode, p, c, k)));
        else
          chk(issue_fire == may_issue(mode, p, c, k), "R5", int'(issue_fire),
              int'(may_issue(mode, p, c, k)));
        chk(stall == !issue_fire, "R9", int'(stall), int'(!issue_fire));
        fired = issue_fire;
      end
      if (mode == MODE_IND) begin
        chk(reg_pending[9] == 1'b0, "R7", int'(reg_pending[9]), 0);
        if (p == 4) chk(div_busy == (k <= 24), "R4", int'(div_busy), int'(k <= 24));
      end else begin
        chk(reg_pending[1] == (left_of(p, k) != 0), "R3", int'(reg_pending[1]),
            int'(left_of(p, k) != 0));
      end
    end
    chk(fired, "R2", int'(fired), 1);
    step();
    idle_req();
    repeat (30) step();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    settle();
    chk(!stall && !issue_fire, "R1", int'(stall || issue_fire), 0);
    chk(reg_pending == '0, "R1", int'(reg_pending != '0), 0);
    chk(!div_busy, "R1", int'(div_busy), 0);
    for (int mode = 0; mode < 3; mode++)
      for (int p = 0; p < 5; p++)
        for (int c = 0; c < 6; c++)
          for (int d = 1; d <= 3; d++)
            run_case(mode, p, c, d);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule